// File: doc/BRIEF.md
# Tracking Converter Step Counter

This block is the digital side of a tracking analog-to-digital converter. An external comparator reports one bit per sample: high when the received signal lies above the level of an external DAC, low when it lies below. On each accepted sample the block moves a 6-bit code one or more LSB towards the signal. The code drives the DAC directly, so the loop follows the input, and the same code is the digitized sample handed to the demodulator.

Receive is enabled with a level input. Each receive session starts the code at mid-scale. For the packet preamble, the block drives a DC-restore control output high (acquire) for a programmable number of samples and then low (hold) for the rest of the session. When the input slews faster than one LSB per sample, an adaptive mode lets the step size grow while the comparator keeps agreeing with itself.

Top module: `trk_adc_counter`

## Requirements
- R1: While `rx_en` is low, and during reset, `code` is 32 (mid-scale), `code_vld` is 0 and `dc_acquire` is 0.
- R2: `code` is an unsigned 6-bit value with bit 5 as MSB. On a sample with the step fixed at 1 (`adapt_en` low), `cmp_hi` = 1 raises `code` by 1 and `cmp_hi` = 0 lowers it by 1.
- R3: `code` changes only on a clock edge where `rx_en`, the internal active state and `smp_en` are all high, or where receive is turned off. Between samples it holds its value.
- R4: `code` saturates: an upward step from near 63 gives 63, and a downward step from near 0 gives 0. It never wraps.
- R5: With `adapt_en` high, after three samples in a row in the same direction the step doubles for the following samples, up to a maximum of 4.
- R6: With `adapt_en` high, a sample whose direction differs from the previous one uses a step of 1 and restarts the run count.
- R7: The first edge with `rx_en` high after idle arms the session, with no sample taken on that edge. `dc_acquire` then goes high if `acq_len` is nonzero, stays high for exactly `acq_len` samples and stays low after that until `rx_en` drops. With `acq_len` = 0 it never goes high.
- R8: `code_vld` is high for one clock after each accepted sample, in the same cycle that the new `code` appears. It is low otherwise.
- R9: After `rx_en` goes low and then high again, the code restarts from 32 and the step restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable (level) |
| smp_en | input | 1 | Sample strobe: take one comparator decision on this edge |
| adapt_en | input | 1 | Selects the adaptive step mode |
| acq_len | input | ACQ_W | Length of the acquire window, in samples |
| cmp_hi | input | 1 | Comparator: 1 means the signal is above the DAC level |
| code | output | CODE_W | DAC code and digitized sample |
| code_vld | output | 1 | One-cycle strobe marking a new code |
| dc_acquire | output | 1 | DC-restore control: 1 = acquire, 0 = hold |

## Verification
A corrupted run counter or step register shows up at `code` on the sample after it occurs. The increment it produces is the wrong size, so the adaptive table walk exposes it within one sample period. A wrong acquire down-counter shifts the falling edge of `dc_acquire` by whole samples, and the check on the exact sample count catches that. Saturation faults appear as a wrap to the opposite end of the range on the first step past a limit, which the bench drives in both directions.

// File: rtl/trk_adc_pkg.sv
package trk_adc_pkg;
    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } trk_dir_e;
endpackage

// File: rtl/trk_step_sel.sv
module trk_step_sel #(
    parameter int STEP_W   = 4,
    parameter int RUN_W    = 2,
    parameter int RUN_LEN  = 3,
    parameter int STEP_MAX = 4
) (
    input  logic              adapt_en,
    input  logic              have_dir,
    input  trk_adc_pkg::trk_dir_e dir_q,
    input  trk_adc_pkg::trk_dir_e dir_now,
    input  logic [STEP_W-1:0] step_q,
    input  logic [RUN_W-1:0]  run_q,
    output logic [STEP_W-1:0] step_now,
    output logic [STEP_W-1:0] step_nxt,
    output logic [RUN_W-1:0]  run_nxt
);
    localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);
    localparam logic [STEP_W-1:0] SMAX = STEP_W'(STEP_MAX);
    localparam logic [RUN_W-1:0]  RLEN = RUN_W'(RUN_LEN);

    logic              same;
    logic [RUN_W-1:0]  run_inc;
    logic [STEP_W-1:0] dbl;

    always_comb begin
        same     = have_dir && (dir_q == dir_now);
        step_now = (adapt_en && same) ? step_q : ONE;
        run_inc  = same ? run_q + RUN_W'(1) : RUN_W'(1);
        dbl      = step_now << 1;
        if (run_inc == RLEN) begin
            run_nxt  = '0;
            step_nxt = !adapt_en ? ONE : ((dbl > SMAX) ? SMAX : dbl);
        end else begin
            run_nxt  = run_inc;
            step_nxt = adapt_en ? step_now : ONE;
        end
    end
endmodule

// File: rtl/trk_sat_step.sv
module trk_sat_step #(
    parameter int CODE_W = 6,
    parameter int STEP_W = 4
) (
    input  logic [CODE_W-1:0] code_q,
    input  logic [STEP_W-1:0] step,
    input  logic              up,
    output logic [CODE_W-1:0] code_nxt
);
    localparam logic [CODE_W:0] TOP = {1'b0, {CODE_W{1'b1}}};

    logic [CODE_W:0] wide_code;
    logic [CODE_W:0] wide_step;
    logic [CODE_W:0] sum;

    always_comb begin
        wide_code = {1'b0, code_q};
        wide_step = '0;
        wide_step[STEP_W-1:0] = step;
        sum = wide_code + wide_step;
        if (up) begin
            code_nxt = (sum > TOP) ? TOP[CODE_W-1:0] : sum[CODE_W-1:0];
        end else begin
            code_nxt = (wide_code < wide_step) ? '0 : (code_q - wide_step[CODE_W-1:0]);
        end
    end
endmodule

// File: rtl/trk_adc_counter.sv
module trk_adc_counter #(
    parameter int CODE_W   = 6,
    parameter int ACQ_W    = 8,
    parameter int RUN_LEN  = 3,
    parameter int STEP_MAX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              smp_en,
    input  logic              adapt_en,
    input  logic [ACQ_W-1:0]  acq_len,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] code,
    output logic              code_vld,
    output logic              dc_acquire
);
    import trk_adc_pkg::*;

    localparam int STEP_W = $clog2(STEP_MAX + 1) + 1;
    localparam int RUN_W  = $clog2(RUN_LEN + 1);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic              active;
        logic [CODE_W-1:0] code;
        logic              vld;
        logic              acq;
        logic [ACQ_W-1:0]  acq_left;
        logic              have_dir;
        trk_dir_e          dir;
        logic [STEP_W-1:0] step;
        logic [RUN_W-1:0]  run;
    } trk_state_t;

    localparam trk_state_t IDLE = '{
        active:   1'b0,
        code:     MID,
        vld:      1'b0,
        acq:      1'b0,
        acq_left: '0,
        have_dir: 1'b0,
        dir:      DIR_DN,
        step:     STEP_W'(1),
        run:      '0
    };

    trk_state_t        st_d, st_q;
    trk_dir_e          dir_now;
    logic [STEP_W-1:0] step_now, step_nxt;
    logic [RUN_W-1:0]  run_nxt;
    logic [CODE_W-1:0] code_nxt;

    assign dir_now = cmp_hi ? DIR_UP : DIR_DN;

    trk_step_sel #(
        .STEP_W(STEP_W), .RUN_W(RUN_W), .RUN_LEN(RUN_LEN), .STEP_MAX(STEP_MAX)
    ) i_step (
        .adapt_en (adapt_en),
        .have_dir (st_q.have_dir),
        .dir_q    (st_q.dir),
        .dir_now  (dir_now),
        .step_q   (st_q.step),
        .run_q    (st_q.run),
        .step_now (step_now),
        .step_nxt (step_nxt),
        .run_nxt  (run_nxt)
    );

    trk_sat_step #(.CODE_W(CODE_W), .STEP_W(STEP_W)) i_sat (
        .code_q   (st_q.code),
        .step     (step_now),
        .up       (cmp_hi),
        .code_nxt (code_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!rx_en) begin
            st_d = IDLE;
        end else if (!st_q.active) begin
            st_d.active   = 1'b1;
            st_d.acq_left = acq_len;
            st_d.acq      = (acq_len != '0);
        end else if (smp_en) begin
            st_d.code     = code_nxt;
            st_d.vld      = 1'b1;
            st_d.have_dir = 1'b1;
            st_d.dir      = dir_now;
            st_d.step     = step_nxt;
            st_d.run      = run_nxt;
            if (st_q.acq_left != '0) begin
                st_d.acq_left = st_q.acq_left - ACQ_W'(1);
                st_d.acq      = (st_q.acq_left != ACQ_W'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE;
        else        st_q <= st_d;
    end

    assign code       = st_q.code;
    assign code_vld   = st_q.vld;
    assign dc_acquire = st_q.acq;
endmodule

// File: rtl/trk_adc_checker.sv
module trk_adc_checker #(
    parameter int CODE_W   = 6,
    parameter int STEP_MAX = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              smp_en,
    input logic              cmp_hi,
    input logic [CODE_W-1:0] code,
    input logic              code_vld,
    input logic              dc_acquire
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    AST_IDLE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (code == MID) && !code_vld && !dc_acquire); // R1

    AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && $past(cmp_hi)) |-> (code >= $past(code))); // R2

    AST_DN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !$past(cmp_hi)) |-> (code <= $past(code))); // R2

    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !smp_en) |=> $stable(code)); // R3

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> (((code >= $past(code)) ? (code - $past(code))
                                             : ($past(code) - code)) <= CODE_W'(STEP_MAX))); // R5

    AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> !code_vld); // R8
endmodule

bind trk_adc_counter trk_adc_checker #(.CODE_W(CODE_W), .STEP_MAX(STEP_MAX)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .smp_en     (smp_en),
    .cmp_hi     (cmp_hi),
    .code       (code),
    .code_vld   (code_vld),
    .dc_acquire (dc_acquire)
);

// File: tb/test_trk_adc_counter.sv
module test_trk_adc_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       smp_en = 1'b0;
    logic       adapt_en = 1'b0;
    logic [7:0] acq_len = 8'd0;
    logic       cmp_hi = 1'b0;
    logic [5:0] code;
    logic       code_vld;
    logic       dc_acquire;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trk_adc_counter i_trk_adc_counter (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .smp_en(smp_en),
        .adapt_en(adapt_en), .acq_len(acq_len), .cmp_hi(cmp_hi),
        .code(code), .code_vld(code_vld), .dc_acquire(dc_acquire)
    );

    // {cmp_hi, expected code} for the adaptive walk starting at 32
    localparam logic [6:0] VEC [0:16] = '{
        {1'b1, 6'd33}, {1'b1, 6'd34}, {1'b1, 6'd35}, {1'b1, 6'd37},
        {1'b1, 6'd39}, {1'b1, 6'd41}, {1'b1, 6'd45}, {1'b1, 6'd49},
        {1'b1, 6'd53}, {1'b1, 6'd57}, {1'b1, 6'd61}, {1'b1, 6'd63},
        {1'b0, 6'd62}, {1'b0, 6'd61}, {1'b0, 6'd60}, {1'b0, 6'd58},
        {1'b1, 6'd59}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input logic c);
        @(negedge clk);
        cmp_hi = c;
        smp_en = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_en = 1'b0;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic start_rx(input logic ad, input logic [7:0] len);
        @(negedge clk);
        smp_en = 1'b0;
        rx_en = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        adapt_en = ad;
        acq_len = len;
        rx_en = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset code", code, 32);
        chk("R1 reset vld", code_vld, 0);
        chk("R1 reset acq", dc_acquire, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        chk("R1 idle code", code, 32);

        // R2 fixed step, R7 acquire window of 4 samples
        start_rx(1'b0, 8'd4);
        chk("R7 acquire after arm", dc_acquire, 1);
        chk("R7 arm takes no sample", code, 32);
        sample(1'b1); chk("R2 up", code, 33); chk("R8 vld", code_vld, 1);
        chk("R7 acq s1", dc_acquire, 1);
        sample(1'b1); chk("R2 up", code, 34);
        sample(1'b1); chk("R2 up", code, 35); chk("R7 acq s3", dc_acquire, 1);
        sample(1'b0); chk("R2 down", code, 34); chk("R7 hold after s4", dc_acquire, 0);
        sample(1'b0); chk("R2 down", code, 33); chk("R7 stays hold", dc_acquire, 0);
        sample(1'b1); chk("R2 fixed step no growth", code, 34);

        // R3 hold, R8 one-cycle strobe
        idle(1);
        chk("R8 strobe drops", code_vld, 0);
        idle(3);
        chk("R3 code held", code, 34);
        chk("R7 hold persists", dc_acquire, 0);

        // R4 saturation at 0, fixed step
        start_rx(1'b0, 8'd0);
        chk("R9 restart mid", code, 32);
        chk("R7 zero window", dc_acquire, 0);
        for (int i = 0; i < 32; i++) sample(1'b0);
        chk("R4 reach 0", code, 0);
        sample(1'b0);
        chk("R4 floor", code, 0);
        chk("R8 vld at floor", code_vld, 1);
        chk("R7 zero window never high", dc_acquire, 0);

        // R5 R6 R4 adaptive table walk
        start_rx(1'b1, 8'd2);
        chk("R9 restart mid adaptive", code, 32);
        for (int i = 0; i < 17; i++) begin
            sample(VEC[i][6]);
            chk((i < 12) ? "R5 adaptive growth / R4 ceiling" : "R6 direction change", code, int'(VEC[i][5:0]));
        end

        // R1 R9 disable and re-enable
        @(negedge clk);
        smp_en = 1'b0;
        rx_en = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 disabled code", code, 32);
        chk("R1 disabled vld", code_vld, 0);
        chk("R1 disabled acq", dc_acquire, 0);
        @(negedge clk);
        rx_en = 1'b1;
        @(posedge clk);
        #1;
        sample(1'b1);
        chk("R9 step restarts at 1", code, 33);
        chk("R7 new window armed", dc_acquire, 1);

        idle(1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule